// File: doc/BRIEF.md
# Piecewise-Linear Gamma Correction Unit

This block applies a programmable transfer curve to every colour component of a pixel stream. The curve has 16 points per component. Each point holds a breakpoint, an intercept and an unsigned gradient. For an input code, the unit picks the point whose segment contains the code. It then returns the gradient times the distance from that breakpoint, plus the intercept. The result is rounded to the pipeline width and clamped to its largest code. Pixels take a fixed two-cycle trip, and a valid flag travels alongside them. A gamma enable input set low turns the unit into a plain two-cycle delay.

Each instance serves one display channel, selected by a parameter. A write-only register bus loads the tables at byte addresses. Every channel's window begins at 0x2000 plus channel × 0x400. Inside a window there are four 128-byte tables in fixed order: red, green, blue, then alpha. Each table holds 16 points of 8 bytes each. The alpha table exists only on display channel 2. On any other channel, alpha passes through unchanged.

A mode input selects the pipeline width. In 12-bit mode, codes are 12 bits and the intercept is unsigned 12.4. In 8-bit mode, only the low 8 input bits count, the breakpoint is the top byte of its field, and the intercept is unsigned 8.8. The reset contents give an identity curve in both modes.

Top module: `pwl_gamma_unit`

## Requirements
- R1: After reset every table holds an identity curve. Point i has breakpoint i×256, raw intercept i×4096 and gradient 256. With gamma enabled, every component therefore leaves equal to its input in 12-bit mode, and equal to its low 8 bits in 8-bit mode.
- R2: A pixel sampled with `pix_in_valid` high appears on `pix_out` with `pix_out_valid` high exactly two clock edges later. After reset, `pix_out_valid` and `pix_out` are zero.
- R3: When `gamma_en` is low at the input cycle, all four 12-bit components come out bit-for-bit equal to the input.
- R4: A write lands only if all of these hold:
  - its byte address is word-aligned;
  - it lies within [base, base+0x200), where base = 0x2000 + CHAN_ID×0x400;
  - the offset from base is component×0x80 + point×8 + word×4, with component 0..3 being red, green, blue, alpha.

  Any other write changes nothing. Word 0 keeps bits [31:20] as breakpoint and bits [15:0] as intercept. Word 1 keeps bits [11:0] as gradient.
- R5: In 12-bit mode (`wide_mode`=1): X is the 12-bit breakpoint, C is unsigned 12.4, and GRAD is unsigned 4.8. The output is round((GRAD×(code−X)) + C), computed with 8 fractional bits.
- R6: In 8-bit mode (`wide_mode`=0):
  - the code is `pix_in` bits [7:0] of the component;
  - X is breakpoint bits [11:4];
  - C is unsigned 8.8 and GRAD is unsigned 4.8;
  - output bits [11:8] are zero.
- R7: The active point is the highest-indexed one whose breakpoint is ≤ the code, whether or not the breakpoints are in ascending order. If no point qualifies, point 0 is used with an offset of zero.
- R8: Rounding adds one half (128 in the 8-fractional-bit sum) and then truncates, so an exact half rounds up.
- R9: Results above 4095 (12-bit mode) or 255 (8-bit mode) saturate at that value.
- R10: Alpha (bits [47:36]) is shaped only when CHAN_ID equals 2. On other channels, alpha-table writes are ignored and alpha passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Table write strobe |
| cfg_addr | input | ADDR_W | Byte address of the write |
| cfg_wdata | input | 32 | Write data |
| wide_mode | input | 1 | 1: 12-bit pipeline, 0: 8-bit pipeline |
| gamma_en | input | 1 | 1: apply curve, 0: pass through |
| pix_in_valid | input | 1 | Input pixel valid |
| pix_in | input | 48 | Components: red [11:0], green [23:12], blue [35:24], alpha [47:36] |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 48 | Corrected pixel, same packing |

## Verification
The assertions assume three things about the inputs:
- reset is held for at least one edge;
- a table is not rewritten while a pixel that uses it is between the segment search and the multiply-add, since the two stages read the table one cycle apart;
- the mode and enable inputs are sampled together with the pixel.

The stimulus keeps within these assumptions in three ways. It issues every register write only after the pipeline has drained. It changes `wide_mode` and `gamma_en` only between bursts. It sends pixels back to back only while the tables are stable. It covers both display-channel variants, plus unsorted breakpoints, half-way intercepts, saturating gradients and writes aimed outside the window.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;

  localparam int PWL_CODE_W = 12;
  localparam int PWL_GRAD_W = 12;
  localparam int PWL_ICPT_W = 16;
  localparam int PWL_COMPS  = 4;
  localparam int PWL_FRAC   = 8;

  typedef struct packed {
    logic [PWL_CODE_W-1:0] bp;
    logic [PWL_ICPT_W-1:0] icpt;
    logic [PWL_GRAD_W-1:0] grad;
  } pwl_pt_t;

  // Breakpoint as seen by the active pipeline width.
  function automatic logic [PWL_CODE_W-1:0] bp_scale(input logic [PWL_CODE_W-1:0] bp,
                                                     input logic wide);
    return wide ? bp : {4'd0, bp[PWL_CODE_W-1:4]};
  endfunction

  // GRAD*offs + C in 8 fractional bits, round half up, clamp to width.
  function automatic logic [PWL_CODE_W-1:0] pwl_eval(input logic [PWL_ICPT_W-1:0] icpt,
                                                     input logic [PWL_GRAD_W-1:0] grad,
                                                     input logic [PWL_CODE_W-1:0] offs,
                                                     input logic wide);
    logic [23:0] prod;
    logic [23:0] base;
    logic [24:0] acc;
    logic [24:0] q;
    logic [PWL_CODE_W-1:0] top_code;
    prod = 24'(grad) * 24'(offs);
    base = wide ? {4'd0, icpt, 4'd0} : {8'd0, icpt};
    acc  = {1'b0, prod} + {1'b0, base} + 25'd128;
    q    = acc >> PWL_FRAC;
    top_code = wide ? 12'hFFF : 12'h0FF;
    if (q > 25'(top_code)) return top_code;
    return q[PWL_CODE_W-1:0];
  endfunction

endpackage

// File: rtl/pwl_point_store.sv
module pwl_point_store
  import pwl_gamma_pkg::*;
#(
  parameter int NPTS = 16,
  parameter int PT_W = $clog2(NPTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_hi,
  input  logic [PT_W-1:0]             wr_pt,
  input  logic [31:0]                 wr_data,
  input  logic [PT_W-1:0]             rd_pt,
  output pwl_pt_t                     rd_val,
  output logic [NPTS-1:0][PWL_CODE_W-1:0] bp_all
);

  pwl_pt_t tbl [NPTS];
  logic unused_rsvd;

  assign unused_rsvd = ^wr_data[19:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPTS; i++) begin
        tbl[i].bp   <= PWL_CODE_W'(i * 256);
        tbl[i].icpt <= PWL_ICPT_W'(i * 4096);
        tbl[i].grad <= PWL_GRAD_W'(256);
      end
    end else if (wr_en) begin
      if (wr_hi) begin
        tbl[wr_pt].grad <= wr_data[PWL_GRAD_W-1:0];
      end else begin
        tbl[wr_pt].bp   <= wr_data[31:20];
        tbl[wr_pt].icpt <= wr_data[PWL_ICPT_W-1:0];
      end
    end
  end

  assign rd_val = tbl[rd_pt];

  for (genvar i = 0; i < NPTS; i++) begin : g_bp
    assign bp_all[i] = tbl[i].bp;
  end

  assert_word0_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (tbl[$past(wr_pt)].bp == $past(wr_data[31:20]) &&
                           tbl[$past(wr_pt)].icpt == $past(wr_data[15:0])));

  assert_word1_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi) |=> (tbl[$past(wr_pt)].grad == $past(wr_data[11:0])));

endmodule

// File: rtl/pwl_seg_find.sv
module pwl_seg_find
  import pwl_gamma_pkg::*;
#(
  parameter int NPTS = 16,
  parameter int PT_W = $clog2(NPTS)
) (
  input  logic [NPTS-1:0][PWL_CODE_W-1:0] bp_all,
  input  logic [PWL_CODE_W-1:0]           code,
  input  logic                            wide,
  output logic [PT_W-1:0]                 seg,
  output logic [PWL_CODE_W-1:0]           seg_bp,
  output logic [PWL_CODE_W-1:0]           offs,
  output logic                            hit
);

  always_comb begin
    seg    = '0;
    seg_bp = '0;
    hit    = 1'b0;
    for (int i = 0; i < NPTS; i++) begin
      if (bp_scale(bp_all[i], wide) <= code) begin
        seg    = PT_W'(i);
        seg_bp = bp_scale(bp_all[i], wide);
        hit    = 1'b1;
      end
    end
    offs = hit ? (code - seg_bp) : '0;
  end

endmodule

// File: rtl/pwl_lane.sv
module pwl_lane
  import pwl_gamma_pkg::*;
#(
  parameter int NPTS  = 16,
  parameter int PT_W  = $clog2(NPTS),
  parameter bit APPLY = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_hi,
  input  logic [PT_W-1:0]       wr_pt,
  input  logic [31:0]           wr_data,
  input  logic [PWL_CODE_W-1:0] in_code,
  input  logic                  wide,
  input  logic                  s1_en,
  input  logic                  s1_wide,
  output logic [PWL_CODE_W-1:0] out_code
);

  pwl_pt_t                         rd_val;
  logic [NPTS-1:0][PWL_CODE_W-1:0] bp_all;
  logic [PWL_CODE_W-1:0]           code_m;
  logic [PT_W-1:0]                 seg;
  logic [PWL_CODE_W-1:0]           seg_bp;
  logic [PWL_CODE_W-1:0]           offs;
  logic                            hit;
  logic                            later_hit;

  logic [PWL_CODE_W-1:0]           s1_code;
  logic [PT_W-1:0]                 s1_seg;
  logic [PWL_CODE_W-1:0]           s1_offs;

  assign code_m = wide ? in_code : {4'd0, in_code[7:0]};

  pwl_point_store #(.NPTS(NPTS), .PT_W(PT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_hi   (wr_hi),
    .wr_pt   (wr_pt),
    .wr_data (wr_data),
    .rd_pt   (s1_seg),
    .rd_val  (rd_val),
    .bp_all  (bp_all)
  );

  pwl_seg_find #(.NPTS(NPTS), .PT_W(PT_W)) u_find (
    .bp_all (bp_all),
    .code   (code_m),
    .wide   (wide),
    .seg    (seg),
    .seg_bp (seg_bp),
    .offs   (offs),
    .hit    (hit)
  );

  // Stage 1: segment choice; stage 2: multiply-add, round, clamp.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_code  <= '0;
      s1_seg   <= '0;
      s1_offs  <= '0;
      out_code <= '0;
    end else begin
      s1_code  <= in_code;
      s1_seg   <= seg;
      s1_offs  <= offs;
      out_code <= (s1_en && APPLY) ? pwl_eval(rd_val.icpt, rd_val.grad, s1_offs, s1_wide)
                                   : s1_code;
    end
  end

  // Independent scan: any qualifying point above the chosen one is an error.
  always_comb begin
    later_hit = 1'b0;
    for (int j = 0; j < NPTS; j++) begin
      if (PT_W'(j) > seg && bp_scale(bp_all[j], wide) <= code_m) later_hit = 1'b1;
    end
  end

  assert_highest_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !later_hit);

  assert_zero_offs_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |-> (offs == '0 && seg == '0));

  assert_narrow_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_en && !s1_wide && APPLY) |=> (out_code[11:8] == 4'd0));

endmodule

// File: rtl/pwl_gamma_unit.sv
module pwl_gamma_unit
  import pwl_gamma_pkg::*;
#(
  parameter int CHAN_ID     = 2,
  parameter int ALPHA_CHAN  = 2,
  parameter int ADDR_W      = 14,
  parameter int BASE_ADDR   = 'h2000,
  parameter int CHAN_STRIDE = 'h400,
  parameter int NPTS        = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_wr_en,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [31:0]                     cfg_wdata,
  input  logic                            wide_mode,
  input  logic                            gamma_en,
  input  logic                            pix_in_valid,
  input  logic [PWL_COMPS*PWL_CODE_W-1:0] pix_in,
  output logic                            pix_out_valid,
  output logic [PWL_COMPS*PWL_CODE_W-1:0] pix_out
);

  localparam int PT_W      = $clog2(NPTS);
  localparam int TBL_BYTES = NPTS * 8;
  localparam int COMP_LSB  = $clog2(TBL_BYTES);
  localparam int WIN_BYTES = PWL_COMPS * TBL_BYTES;
  localparam int CH_BASE   = BASE_ADDR + CHAN_ID * CHAN_STRIDE;
  localparam bit HAS_ALPHA = (CHAN_ID == ALPHA_CHAN);
  localparam int ALPHA_LSB = 3 * PWL_CODE_W;

  logic [ADDR_W-1:0]    rel;
  logic                 in_win;
  logic [1:0]           comp_sel;
  logic [PT_W-1:0]      pt_sel;
  logic                 hi_sel;
  logic [PWL_COMPS-1:0] tbl_we;

  logic                  s1_valid;
  logic                  s1_en;
  logic                  s1_wide;
  logic [PWL_CODE_W-1:0] lane_out [PWL_COMPS];

  // Register window decode.
  assign rel      = cfg_addr - ADDR_W'(CH_BASE);
  assign in_win   = (cfg_addr >= ADDR_W'(CH_BASE)) && (rel < ADDR_W'(WIN_BYTES)) &&
                    (rel[1:0] == 2'b00);
  assign comp_sel = rel[COMP_LSB +: 2];
  assign pt_sel   = rel[3 +: PT_W];
  assign hi_sel   = rel[2];

  for (genvar c = 0; c < PWL_COMPS; c++) begin : g_we
    assign tbl_we[c] = cfg_wr_en && in_win && (comp_sel == 2'(c)) &&
                       ((c != PWL_COMPS - 1) || HAS_ALPHA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid      <= 1'b0;
      s1_en         <= 1'b0;
      s1_wide       <= 1'b0;
      pix_out_valid <= 1'b0;
    end else begin
      s1_valid      <= pix_in_valid;
      s1_en         <= gamma_en;
      s1_wide       <= wide_mode;
      pix_out_valid <= s1_valid;
    end
  end

  for (genvar c = 0; c < PWL_COMPS; c++) begin : g_lane
    localparam bit LANE_APPLY = (c != PWL_COMPS - 1) || HAS_ALPHA;
    pwl_lane #(.NPTS(NPTS), .PT_W(PT_W), .APPLY(LANE_APPLY)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_we[c]),
      .wr_hi    (hi_sel),
      .wr_pt    (pt_sel),
      .wr_data  (cfg_wdata),
      .in_code  (pix_in[c*PWL_CODE_W +: PWL_CODE_W]),
      .wide     (wide_mode),
      .s1_en    (s1_en),
      .s1_wide  (s1_wide),
      .out_code (lane_out[c])
    );
    assign pix_out[c*PWL_CODE_W +: PWL_CODE_W] = lane_out[c];
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_valid |-> ##2 pix_out_valid);

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_in_valid && !gamma_en) |-> ##2 (pix_out == $past(pix_in, 2)));

  if (!HAS_ALPHA) begin : g_alpha_pass
    assert_alpha_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_in_valid |-> ##2 (pix_out[ALPHA_LSB +: PWL_CODE_W] ==
                            $past(pix_in[ALPHA_LSB +: PWL_CODE_W], 2)));
  end

endmodule

// File: tb/test_pwl_gamma_unit.sv
`timescale 1ns/1ps
module test_pwl_gamma_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [13:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        wide_mode = 1'b1;
  logic        gamma_en = 1'b1;
  logic        pix_in_valid = 1'b0;
  logic [47:0] pix_in = '0;
  logic        o_v0, o_v1;
  logic [47:0] o_pix0, o_pix1;

  int nchk = 0;
  int nfail = 0;
  int unsigned seed = 32'h1234_5679;

  logic [11:0] m_bp [2][4][16];
  logic [15:0] m_ic [2][4][16];
  logic [11:0] m_gr [2][4][16];

  logic [47:0] q0[$], q1[$];
  string       t0[$], t1[$];

  always #10 clk = ~clk;

  pwl_gamma_unit #(.CHAN_ID(2)) i_pwl_gamma_unit (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wide_mode(wide_mode), .gamma_en(gamma_en),
    .pix_in_valid(pix_in_valid), .pix_in(pix_in),
    .pix_out_valid(o_v0), .pix_out(o_pix0));

  pwl_gamma_unit #(.CHAN_ID(0)) i_pwl_gamma_unit_c0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wide_mode(wide_mode), .gamma_en(gamma_en),
    .pix_in_valid(pix_in_valid), .pix_in(pix_in),
    .pix_out_valid(o_v1), .pix_out(o_pix1));

  function automatic int unsigned nxt();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [47:0] mk(int r, int g, int b, int a);
    return {12'(a), 12'(b), 12'(g), 12'(r)};
  endfunction

  function automatic int pa(int ch, int comp, int pt, int hi);
    return 'h2000 + ch * 'h400 + comp * 128 + pt * 8 + hi * 4;
  endfunction

  function automatic int w0(int x, int c);
    return (x << 20) | (c & 'hFFFF);
  endfunction

  task automatic model_reset();
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < 4; c++)
        for (int i = 0; i < 16; i++) begin
          m_bp[d][c][i] = 12'(i * 256);
          m_ic[d][c][i] = 16'(i * 4096);
          m_gr[d][c][i] = 12'd256;
        end
  endtask

  // Expected component value, written from the requirement text.
  function automatic int exp_comp(int d, int c, int code, bit wide, bit en);
    int cm, mx, seg, x, offs, v, r;
    bit hit;
    if (!en) return code;                  // R3
    if (c == 3 && d == 1) return code;     // R10
    cm = wide ? code : code % 256;
    mx = wide ? 4095 : 255;
    seg = 0; hit = 0;
    for (int i = 0; i < 16; i++) begin
      x = wide ? int'(m_bp[d][c][i]) : int'(m_bp[d][c][i]) / 16;
      if (x <= cm) begin seg = i; hit = 1; end
    end
    x = wide ? int'(m_bp[d][c][seg]) : int'(m_bp[d][c][seg]) / 16;
    offs = hit ? cm - x : 0;
    v = int'(m_gr[d][c][seg]) * offs + (wide ? int'(m_ic[d][c][seg]) * 16 : int'(m_ic[d][c][seg]));
    r = (v + 128) / 256;
    if (r > mx) r = mx;
    return r;
  endfunction

  function automatic logic [47:0] exp_pix(int d, logic [47:0] p);
    logic [47:0] e;
    for (int c = 0; c < 4; c++)
      e[c*12 +: 12] = 12'(exp_comp(d, c, int'(p[c*12 +: 12]), wide_mode, gamma_en));
    return e;
  endfunction

  task automatic wr(input int addr, input int data);
    int base, rel, comp, pt, hi, ch;
    @(posedge clk); #2;
    cfg_wr_en = 1'b1; cfg_addr = 14'(addr); cfg_wdata = 32'(data);
    @(posedge clk); #2;
    cfg_wr_en = 1'b0;
    for (int d = 0; d < 2; d++) begin
      ch = (d == 0) ? 2 : 0;
      base = 'h2000 + ch * 'h400;
      rel = addr - base;
      if (rel >= 0 && rel < 512 && rel % 4 == 0) begin
        comp = rel / 128; pt = (rel / 8) % 16; hi = (rel / 4) % 2;
        if (!(comp == 3 && ch != 2)) begin
          if (hi == 1) m_gr[d][comp][pt] = 12'(data);
          else begin
            m_bp[d][comp][pt] = 12'(data >> 20);
            m_ic[d][comp][pt] = 16'(data);
          end
        end
      end
    end
  endtask

  task automatic px(input logic [47:0] p, input string tag);
    @(posedge clk); #2;
    pix_in = p; pix_in_valid = 1'b1;
    q0.push_back(exp_pix(0, p)); t0.push_back(tag);
    q1.push_back(exp_pix(1, p)); t1.push_back(tag);
  endtask

  task automatic drain();
    @(posedge clk); #2;
    pix_in_valid = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [47:0] got, input logic [47:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n) begin
      if (o_v0) begin
        if (q0.size() == 0) check(1'b0, "R2 unexpected output ch2", o_pix0, '0);
        else begin
          logic [47:0] e; string t;
          e = q0.pop_front(); t = t0.pop_front();
          check(o_pix0 === e, {t, " ch2"}, o_pix0, e);
        end
      end
      if (o_v1) begin
        if (q1.size() == 0) check(1'b0, "R2 unexpected output ch0", o_pix1, '0);
        else begin
          logic [47:0] e; string t;
          e = q1.pop_front(); t = t1.pop_front();
          check(o_pix1 === e, {t, " ch0"}, o_pix1, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", '0, 48'd1);
    summary();
  end

  initial begin
    int lat;
    bit got;
    model_reset();
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(o_v0 == 1'b0 && o_pix0 == '0, "R2 reset state ch2", o_pix0, '0);
    check(o_v1 == 1'b0 && o_pix1 == '0, "R2 reset state ch0", o_pix1, '0);

    // R1: identity after reset, 12-bit then 8-bit
    wide_mode = 1'b1; gamma_en = 1'b1;
    px(mk(0, 'hFFF, 'h100, 'h7FF), "R1 identity 12-bit");
    px(mk('hABC, 'h0FF, 'h800, 1), "R1 identity 12-bit");
    for (int k = 0; k < 8; k++) px(48'({nxt(), nxt()}), "R1 identity 12-bit");
    drain();
    wide_mode = 1'b0;
    px(mk('hA5C, 'hFFF, 0, 'h1FF), "R1 R6 identity 8-bit");
    for (int k = 0; k < 6; k++) px(48'({nxt(), nxt()}), "R1 R6 identity 8-bit");
    drain();

    // R3: bypass
    gamma_en = 1'b0;
    wide_mode = 1'b1;
    for (int k = 0; k < 6; k++) px(48'({nxt(), nxt()}), "R3 bypass 12-bit");
    drain();
    wide_mode = 1'b0;
    for (int k = 0; k < 4; k++) px(48'({nxt(), nxt()}), "R3 bypass 8-bit");
    drain();
    gamma_en = 1'b1;

    // R5/R6: programmed curves, red sorted on both channels, green unsorted on ch2
    for (int p = 0; p < 16; p++) begin
      int x, c, g;
      x = p * 256 + int'(nxt() % 200); c = int'(nxt() % 65536); g = int'(nxt() % 4096);
      wr(pa(2, 0, p, 0), w0(x, c)); wr(pa(2, 0, p, 1), g);
      wr(pa(0, 0, p, 0), w0(x, c)); wr(pa(0, 0, p, 1), g);
      wr(pa(2, 1, p, 0), w0(int'(nxt() % 4096), int'(nxt() % 65536)));
      wr(pa(2, 1, p, 1), int'(nxt() % 600));
    end
    wide_mode = 1'b1;
    for (int k = 0; k < 16; k++) px(48'({nxt(), nxt()}), "R5 12-bit curve");
    drain();
    wide_mode = 1'b0;
    for (int k = 0; k < 12; k++) px(48'({nxt(), nxt()}), "R6 8-bit curve");
    drain();

    // R8: rounding on blue, ch2
    for (int p = 1; p < 16; p++) begin
      wr(pa(2, 2, p, 0), w0('hFFF, 0)); wr(pa(2, 2, p, 1), 0);
    end
    wr(pa(2, 2, 0, 0), w0(0, 'h0008)); wr(pa(2, 2, 0, 1), 0);
    wide_mode = 1'b1;
    px(mk(0, 0, 'h123, 0), "R8 half rounds up 12-bit");
    drain();
    wr(pa(2, 2, 0, 0), w0(0, 'h0007));
    px(mk(0, 0, 'h123, 0), "R8 below half 12-bit");
    drain();
    wide_mode = 1'b0;
    wr(pa(2, 2, 0, 0), w0(0, 'h0080));
    px(mk(0, 0, 'h23, 0), "R8 half rounds up 8-bit");
    drain();
    wr(pa(2, 2, 0, 0), w0(0, 'h007F));
    px(mk(0, 0, 'h23, 0), "R8 below half 8-bit");
    drain();

    // R9: saturation on red, ch2
    for (int p = 0; p < 16; p++) begin
      wr(pa(2, 0, p, 0), w0(p == 0 ? 0 : 'hFFF, 'hFFFF)); wr(pa(2, 0, p, 1), 'hFFF);
    end
    wide_mode = 1'b1;
    px(mk('h800, 0, 0, 0), "R9 saturate 12-bit");
    px(mk('hFFF, 0, 0, 0), "R9 saturate 12-bit");
    drain();
    wide_mode = 1'b0;
    px(mk('h080, 0, 0, 0), "R9 saturate 8-bit");
    drain();

    // R7: segment choice on green, ch2
    for (int p = 1; p < 16; p++) begin
      wr(pa(2, 1, p, 0), w0('hFFF, 'hFFF0)); wr(pa(2, 1, p, 1), 0);
    end
    wr(pa(2, 1, 0, 0), w0('h100, 'h1230)); wr(pa(2, 1, 0, 1), 'h200);
    wr(pa(2, 1, 7, 0), w0('h200, 'h4000)); wr(pa(2, 1, 7, 1), 'h100);
    wide_mode = 1'b1;
    px(mk(0, 'h050, 0, 0), "R7 below first breakpoint");
    px(mk(0, 'h180, 0, 0), "R7 inside point 0");
    px(mk(0, 'h300, 0, 0), "R7 unsorted highest index");
    px(mk(0, 'hFFF, 0, 0), "R7 last point");
    drain();

    // R10: alpha tables
    for (int p = 0; p < 16; p++) begin
      wr(pa(2, 3, p, 0), w0(p * 256, 'h8000)); wr(pa(2, 3, p, 1), 0);
      wr(pa(0, 3, p, 0), w0(0, 0)); wr(pa(0, 3, p, 1), 0);
    end
    for (int k = 0; k < 6; k++) px(48'({nxt(), nxt()}), "R10 alpha shaping");
    drain();

    // R4: writes outside the window or unaligned are ignored; green decode on ch0
    wr(pa(0, 0, 0, 0) + 'h200, w0(0, 'hFFFF));
    wr(pa(0, 0, 3, 0) + 1, w0(0, 'hFFFF));
    wr('h2C00, w0(0, 'hFFFF));
    wr('h1FF8, w0(0, 'hFFFF));
    wr(pa(0, 1, 2, 0), w0('h200, 'h5000)); wr(pa(0, 1, 2, 1), 'h080);
    for (int k = 0; k < 8; k++) px(48'({nxt(), nxt()}), "R4 map and ignored writes");
    px(mk('h010, 'h250, 'h300, 'h400), "R4 map and ignored writes");
    drain();

    // R2: latency of a single pixel
    px(mk(1, 2, 3, 4), "R2 single pixel");
    lat = 0; got = 0;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk);
      if (k == 1) begin #2 pix_in_valid = 1'b0; end
      @(negedge clk);
      if (o_v0 && !got) begin got = 1; lat = k; end
    end
    check(lat == 2, "R2 latency", 48'(lat), 48'd2);
    repeat (3) @(posedge clk);
    check(q0.size() == 0 && q1.size() == 0, "R2 all outputs delivered",
          48'(q0.size() + q1.size()), 48'd0);
    summary();
  end

endmodule